// File: doc/BRIEF.md
# Synchronous Serial Port Channel

This block is a clocked serial unit with one transmit channel and one receive channel. Each channel is set up through an 8-bit control register and moves data through a byte buffer register. The transmitter generates its own serial clock from a programmable half-period divider that advances on a cycle-enable tick. It changes its data pin on each falling edge of that clock. The receiver has no clock of its own. It samples its data pin on each rising edge of an externally supplied clock, after both pins pass through a synchronizer.

Software sets up a channel by writing its frame length, bit order and interrupt enable, then sets the run bit. The run bit stays high while the frame is in progress, and hardware clears it when the last bit completes. At that point the done flag rises, and it stays set until software writes it to 0. If the receiver completes a frame while its done flag is still set, the new byte is dropped and the overrun flag rises. If software writes the transmit buffer while a frame is in flight, the write is dropped and the transmit overrun flag rises.

Top module: `syncSerialPort`

## Requirements
- R1: After reset, every register reads 0, the transmit clock pin and the transmit data pin are 1, and both interrupt outputs are 0.
- R2: Writing the transmit control register (address 0) with bit 3 = 1 while bit 3 is 0 starts a frame. Bit 3 reads 1 until the last bit completes, then clears, and in the same cycle the done flag (bit 1) sets.
- R3: Each half period of the transmit clock lasts (256 − baud) cycles in which tickEn is high. The clock idles high. The data pin changes only on falling edges. A frame ends on its last rising edge.
- R4: Control bit 4 selects the frame length: 0 gives 8 bits and 1 gives 7 bits. A 7-bit frame carries the low 7 bits of the byte, and a 7-bit receive sets buffer bit 7 to 0.
- R5: Control bit 2 selects the bit order on either channel: 1 sends or receives the most significant bit first, and 0 the least significant bit first.
- R6: Transmit control bit 7 = 1 drives the internal serial clock onto txClk. With bit 7 = 0, txClk stays 1 while the frame still runs.
- R7: Writing the receive control register (address 4) with bit 3 = 1 arms the receiver. It then takes rxData on each synchronized rising edge of rxClk. After the last bit it loads the buffer (address 5), clears bit 3 and sets bit 1. Rising edges that arrive while the receiver is not armed change nothing.
- R8: A receive frame that completes while bit 1 is still set sets bit 6 (overrun) and leaves the receive buffer unchanged.
- R9: A write to the transmit buffer (address 1) while bit 3 is 1 is dropped and sets transmit bit 6.
- R10: Writing 0 to bit 1 or bit 6 clears that bit, and writing 1 leaves it as it is. Writing bit 3 = 0 during a frame does not stop the frame.
- R11: Each interrupt output is 1 exactly when its channel has bit 0 and bit 1 both set.
- R12: The register map is: address 0 transmit control, 1 transmit buffer, 2 baud, 4 receive control, 5 receive buffer (read-only). Reads are combinational. Bit 5 of both control registers and bit 7 of the receive control register always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Cycle-enable tick that advances the baud divider |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 3 | Register write address |
| regWrData | input | 8 | Register write data |
| regRdAddr | input | 3 | Register read address |
| regRdData | output | 8 | Register read data (combinational) |
| txClk | output | 1 | Transmit serial clock pin |
| txData | output | 1 | Transmit serial data pin |
| rxClk | input | 1 | Receive serial clock from the far end |
| rxData | input | 1 | Receive serial data |
| txIrq | output | 1 | Transmit interrupt request |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with the default two-stage synchronizer and uses baud values 0xFE, 0xFD and 0xF0. These give half periods of 2, 3 and 16 ticks, so a full frame takes tens to a few hundred cycles. With the baud at 0xFD, tickEn is gated to one cycle in three. This checks that the divider counts ticks and not clock cycles. With the two-stage synchronizer and a 2-tick half period, the receiver samples close to the data edge, so the loopback shows whether data and clock stay aligned through the synchronizer. Receive overrun, edges arriving while the receiver is not armed, and a receiver left armed when the transmit clock is gated off are set up by driving the receive pins directly.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  // register addresses
  localparam logic [ADDR_W-1:0] ADDR_TX_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_TX_BUF  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_BAUD    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_RX_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_RX_BUF  = 3'd5;

  // control bit positions, shared by both channels
  localparam int B_IE   = 0;
  localparam int B_DONE = 1;
  localparam int B_MSB  = 2;
  localparam int B_RUN  = 3;
  localparam int B_LEN7 = 4;
  localparam int B_OVR  = 6;
  localparam int B_CKEN = 7;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic              txLoad;
    logic              txLen7;
    logic              txMsb;
    logic [BYTE_W-1:0] txByte;
    logic [BYTE_W-1:0] baud;
    logic              clkOutEn;
    logic              rxArm;
    logic              rxLen7;
    logic              rxMsb;
  } sspCmd_t;

  // events from datapath back to control
  typedef struct packed {
    logic              txFinish;
    logic              rxFinish;
    logic [BYTE_W-1:0] rxWord;
  } sspEvt_t;
endpackage

// File: rtl/sspCtrl.sv
module sspCtrl
  import ssp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  input  sspEvt_t           evt,
  output sspCmd_t           cmd,
  output logic              txIrq,
  output logic              rxIrq,
  output logic [BYTE_W-1:0] txCtrlQ,
  output logic [BYTE_W-1:0] rxCtrlQ,
  output logic [BYTE_W-1:0] txBufQ,
  output logic [BYTE_W-1:0] rxBufQ
);
  logic [BYTE_W-1:0] txCtrl, rxCtrl, txBuf, rxBuf, baud;

  logic txCtrlWr, txBufWr, baudWr, rxCtrlWr, txStart, rxStart;
  assign txCtrlWr = wrEn && (wrAddr == ADDR_TX_CTRL);
  assign txBufWr  = wrEn && (wrAddr == ADDR_TX_BUF);
  assign baudWr   = wrEn && (wrAddr == ADDR_BAUD);
  assign rxCtrlWr = wrEn && (wrAddr == ADDR_RX_CTRL);
  assign txStart  = txCtrlWr && wrData[B_RUN] && !txCtrl[B_RUN];
  assign rxStart  = rxCtrlWr && wrData[B_RUN] && !rxCtrl[B_RUN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCtrl <= '0;
      rxCtrl <= '0;
      txBuf  <= '0;
      rxBuf  <= '0;
      baud   <= '0;
    end else begin
      if (txCtrlWr) begin
        txCtrl[B_IE]   <= wrData[B_IE];
        txCtrl[B_MSB]  <= wrData[B_MSB];
        txCtrl[B_LEN7] <= wrData[B_LEN7];
        txCtrl[B_CKEN] <= wrData[B_CKEN];
        if (!wrData[B_DONE]) txCtrl[B_DONE] <= 1'b0;
        if (!wrData[B_OVR])  txCtrl[B_OVR]  <= 1'b0;
        if (txStart)         txCtrl[B_RUN]  <= 1'b1;
      end
      if (txBufWr) begin
        if (txCtrl[B_RUN]) txCtrl[B_OVR] <= 1'b1;
        else               txBuf <= wrData;
      end
      if (baudWr) baud <= wrData;
      if (evt.txFinish) begin
        txCtrl[B_RUN]  <= 1'b0;
        txCtrl[B_DONE] <= 1'b1;
      end

      if (rxCtrlWr) begin
        rxCtrl[B_IE]   <= wrData[B_IE];
        rxCtrl[B_MSB]  <= wrData[B_MSB];
        rxCtrl[B_LEN7] <= wrData[B_LEN7];
        if (!wrData[B_DONE]) rxCtrl[B_DONE] <= 1'b0;
        if (!wrData[B_OVR])  rxCtrl[B_OVR]  <= 1'b0;
        if (rxStart)         rxCtrl[B_RUN]  <= 1'b1;
      end
      if (evt.rxFinish) begin
        rxCtrl[B_RUN] <= 1'b0;
        if (rxCtrl[B_DONE]) begin
          rxCtrl[B_OVR] <= 1'b1;
        end else begin
          rxBuf          <= evt.rxWord;
          rxCtrl[B_DONE] <= 1'b1;
        end
      end
    end
  end

  assign cmd = '{txLoad:   txStart,
                 txLen7:   wrData[B_LEN7],
                 txMsb:    wrData[B_MSB],
                 txByte:   txBuf,
                 baud:     baud,
                 clkOutEn: txCtrl[B_CKEN],
                 rxArm:    rxStart,
                 rxLen7:   wrData[B_LEN7],
                 rxMsb:    wrData[B_MSB]};

  always_comb begin
    case (rdAddr)
      ADDR_TX_CTRL: rdData = txCtrl;
      ADDR_TX_BUF:  rdData = txBuf;
      ADDR_BAUD:    rdData = baud;
      ADDR_RX_CTRL: rdData = rxCtrl;
      ADDR_RX_BUF:  rdData = rxBuf;
      default:      rdData = '0;
    endcase
  end

  assign txIrq   = txCtrl[B_IE] && txCtrl[B_DONE];
  assign rxIrq   = rxCtrl[B_IE] && rxCtrl[B_DONE];
  assign txCtrlQ = txCtrl;
  assign rxCtrlQ = rxCtrl;
  assign txBufQ  = txBuf;
  assign rxBufQ  = rxBuf;
endmodule

// File: rtl/sspDatapath.sv
module sspDatapath
  import ssp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tickEn,
  input  sspCmd_t cmd,
  output sspEvt_t evt,
  input  logic    rxClk,
  input  logic    rxData,
  output logic    txClk,
  output logic    txData
);
  // ---------------- transmit ----------------
  logic [BYTE_W-1:0] txShadow, halfCnt;
  logic              txLen7q, txMsbq, txActive, sclkQ, txOutQ;
  logic [CNT_W-1:0]  txBitCnt, frameLenTx, txIdx;
  logic              halfDone, txFin;

  assign frameLenTx = txLen7q ? CNT_W'(BYTE_W - 1) : CNT_W'(BYTE_W);
  assign txIdx      = txMsbq ? CNT_W'(frameLenTx - CNT_W'(1) - txBitCnt) : txBitCnt;
  assign halfDone   = txActive && tickEn && (halfCnt >= ~cmd.baud);
  assign txFin      = halfDone && !sclkQ && (txBitCnt == CNT_W'(frameLenTx - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShadow <= '0;
      halfCnt  <= '0;
      txLen7q  <= 1'b0;
      txMsbq   <= 1'b0;
      txActive <= 1'b0;
      sclkQ    <= 1'b1;
      txOutQ   <= 1'b1;
      txBitCnt <= '0;
    end else if (cmd.txLoad) begin
      txShadow <= cmd.txByte;
      txLen7q  <= cmd.txLen7;
      txMsbq   <= cmd.txMsb;
      txActive <= 1'b1;
      halfCnt  <= '0;
      txBitCnt <= '0;
      sclkQ    <= 1'b1;
    end else if (txActive && tickEn) begin
      if (halfDone) begin
        halfCnt <= '0;
        if (sclkQ) begin
          sclkQ  <= 1'b0;
          txOutQ <= txShadow[txIdx[$clog2(BYTE_W)-1:0]];
        end else begin
          sclkQ    <= 1'b1;
          txBitCnt <= txBitCnt + CNT_W'(1);
          if (txFin) txActive <= 1'b0;
        end
      end else begin
        halfCnt <= halfCnt + BYTE_W'(1);
      end
    end
  end

  assign txClk  = cmd.clkOutEn ? sclkQ : 1'b1;
  assign txData = txOutQ;

  // ---------------- receive ----------------
  logic [SYNC_STAGES-1:0] clkSyn, datSyn;
  logic                   clkPrev, rxRise, rxBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSyn  <= '1;
      datSyn  <= '0;
      clkPrev <= 1'b1;
    end else begin
      clkSyn  <= {clkSyn[SYNC_STAGES-2:0], rxClk};
      datSyn  <= {datSyn[SYNC_STAGES-2:0], rxData};
      clkPrev <= clkSyn[SYNC_STAGES-1];
    end
  end

  assign rxRise = clkSyn[SYNC_STAGES-1] && !clkPrev;
  assign rxBit  = datSyn[SYNC_STAGES-1];

  logic [BYTE_W-1:0] rxShift, newShift, rxWordC;
  logic [CNT_W-1:0]  rxCnt, frameLenRx;
  logic              rxActive, rxLen7q, rxMsbq, rxFin;

  assign frameLenRx = rxLen7q ? CNT_W'(BYTE_W - 1) : CNT_W'(BYTE_W);
  assign newShift   = rxMsbq ? {rxShift[BYTE_W-2:0], rxBit} : {rxBit, rxShift[BYTE_W-1:1]};
  assign rxWordC    = (!rxMsbq && rxLen7q) ? {1'b0, newShift[BYTE_W-1:1]} : newShift;
  assign rxFin      = rxActive && rxRise && (rxCnt == CNT_W'(frameLenRx - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift  <= '0;
      rxCnt    <= '0;
      rxActive <= 1'b0;
      rxLen7q  <= 1'b0;
      rxMsbq   <= 1'b0;
    end else if (cmd.rxArm) begin
      rxShift  <= '0;
      rxCnt    <= '0;
      rxActive <= 1'b1;
      rxLen7q  <= cmd.rxLen7;
      rxMsbq   <= cmd.rxMsb;
    end else if (rxActive && rxRise) begin
      rxShift <= newShift;
      rxCnt   <= rxCnt + CNT_W'(1);
      if (rxFin) rxActive <= 1'b0;
    end
  end

  assign evt = '{txFinish: txFin, rxFinish: rxFin, rxWord: rxWordC};
endmodule

// File: rtl/syncSerialPort.sv
module syncSerialPort
  import ssp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [BYTE_W-1:0] regRdData,
  output logic              txClk,
  output logic              txData,
  input  logic              rxClk,
  input  logic              rxData,
  output logic              txIrq,
  output logic              rxIrq
);
  sspCmd_t           cmd;
  sspEvt_t           evt;
  logic [BYTE_W-1:0] txCtrlQ, rxCtrlQ, txBufQ, rxBufQ;

  sspCtrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .wrEn(regWrEn), .wrAddr(regWrAddr), .wrData(regWrData),
    .rdAddr(regRdAddr), .rdData(regRdData),
    .evt(evt), .cmd(cmd),
    .txIrq(txIrq), .rxIrq(rxIrq),
    .txCtrlQ(txCtrlQ), .rxCtrlQ(rxCtrlQ), .txBufQ(txBufQ), .rxBufQ(rxBufQ)
  );

  sspDatapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .cmd(cmd), .evt(evt),
    .rxClk(rxClk), .rxData(rxData),
    .txClk(txClk), .txData(txData)
  );
endmodule

// File: rtl/sspChecker.sv
module sspChecker (
  input logic       clk,
  input logic       rstN,
  input logic       txClk,
  input logic       txData,
  input logic [7:0] txCtrl,
  input logic [7:0] rxCtrl,
  input logic [7:0] txBuf,
  input logic [7:0] rxBuf
);
  // R2: end of a transmit frame raises the done flag
  a_r2_end_sets_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txCtrl[3]) |-> txCtrl[1]);

  // R3: with the clock pin enabled, data moves only together with a falling clock
  a_r3_data_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(txData) && txCtrl[7] && $past(txCtrl[7])) |-> $fell(txClk));

  // R3: an idle transmitter leaves an enabled clock pin high
  a_r3_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    (!txCtrl[3] && txCtrl[7]) |-> txClk);

  // R7: end of a receive frame leaves the done flag set
  a_r7_end_sets_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxCtrl[3]) |-> rxCtrl[1]);

  // R8: an overrun never replaces the buffered byte
  a_r8_overrun_keeps_buf: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxCtrl[6]) |-> $stable(rxBuf));

  // R9: the transmit buffer is frozen while a frame runs
  a_r9_buf_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (txCtrl[3] && $past(txCtrl[3])) |-> $stable(txBuf));
endmodule

bind syncSerialPort sspChecker chk_i (
  .clk(clk), .rstN(rstN), .txClk(txClk), .txData(txData),
  .txCtrl(txCtrlQ), .rxCtrl(rxCtrlQ), .txBuf(txBufQ), .rxBuf(rxBufQ)
);

// File: tb/syncSerialPort_tb_top.sv
`timescale 1ns/1ps
module syncSerialPort_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic       regWrEn = 1'b0;
  logic [2:0] regWrAddr = '0;
  logic [7:0] regWrData = '0;
  logic [2:0] regRdAddr = '0;
  logic [7:0] regRdData;
  logic       txClk, txData, txIrq, rxIrq;
  logic       loopSel = 1'b1;
  logic       manClk = 1'b1;
  logic       manData = 1'b0;
  logic       rxClk, rxData;
  logic       gateTicks = 1'b0;
  logic       monLow = 1'b0;
  int         lowSeen = 0;
  int         tickCnt = 0;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  assign rxClk  = loopSel ? txClk : manClk;
  assign rxData = loopSel ? txData : manData;

  syncSerialPort dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData),
    .txClk(txClk), .txData(txData), .rxClk(rxClk), .rxData(rxData),
    .txIrq(txIrq), .rxIrq(rxIrq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural transmit model ----------------
  bit [7:0] mCtrl, mBuf, mBaud, mSh;
  bit       mLen7, mMsb, expClkInt, expData, wasBusy, fin;
  int       tickAcc, halves, nBits, idx;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mBuf = 0; mBaud = 0; mSh = 0; mLen7 = 0; mMsb = 0;
      expClkInt = 1; expData = 1; tickAcc = 0; halves = 0;
    end else begin
      wasBusy = mCtrl[3];
      fin = 0;
      if (wasBusy && tickEn) begin
        tickAcc++;
        if (tickAcc >= 256 - int'(mBaud)) begin
          tickAcc = 0;
          halves++;
          nBits = mLen7 ? 7 : 8;
          if (halves % 2 == 1) begin
            expClkInt = 0;
            idx = (halves - 1) / 2;
            expData = mMsb ? mSh[nBits-1-idx] : mSh[idx];
          end else begin
            expClkInt = 1;
            if (halves == 2 * nBits) fin = 1;
          end
        end
      end
      if (regWrEn && regWrAddr == 3'd0) begin
        mCtrl[0] = regWrData[0]; mCtrl[2] = regWrData[2];
        mCtrl[4] = regWrData[4]; mCtrl[7] = regWrData[7];
        if (!regWrData[1]) mCtrl[1] = 0;
        if (!regWrData[6]) mCtrl[6] = 0;
        if (regWrData[3] && !wasBusy) begin
          mCtrl[3] = 1; mSh = mBuf; mLen7 = regWrData[4]; mMsb = regWrData[2];
          tickAcc = 0; halves = 0;
        end
      end
      if (regWrEn && regWrAddr == 3'd1) begin
        if (wasBusy) mCtrl[6] = 1;
        else mBuf = regWrData;
      end
      if (regWrEn && regWrAddr == 3'd2) mBaud = regWrData;
      if (fin) begin mCtrl[3] = 0; mCtrl[1] = 1; end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      check(txClk == (mCtrl[7] ? expClkInt : 1'b1), "R3/R6 txClk", int'(txClk), int'(mCtrl[7] ? expClkInt : 1'b1));
      check(txData == expData, "R3/R5 txData", int'(txData), int'(expData));
      check(txIrq == (mCtrl[0] & mCtrl[1]), "R11 txIrq", int'(txIrq), int'(mCtrl[0] & mCtrl[1]));
      if (regRdAddr == 3'd0)
        check(regRdData == mCtrl, "R2 tx control", int'(regRdData), int'(mCtrl));
      if (monLow && !txClk) lowSeen++;
    end
  end

  always @(negedge clk) begin
    if (gateTicks) begin
      tickCnt++;
      tickEn <= (tickCnt % 3 == 0);
    end else begin
      tickEn <= 1'b1;
    end
  end

  task automatic wr(input bit [2:0] a, input bit [7:0] d);
    @(negedge clk); #1;
    regWrEn = 1; regWrAddr = a; regWrData = d;
    @(negedge clk); #1;
    regWrEn = 0;
  endtask

  task automatic rd(input bit [2:0] a, output bit [7:0] v);
    @(negedge clk); #1;
    regRdAddr = a; #1;
    v = regRdData;
    regRdAddr = 3'd0;
  endtask

  task automatic waitIdle(input bit [2:0] a, input string req);
    bit [7:0] v;
    bit       ok = 0;
    for (int i = 0; i < 5000; i++) begin
      rd(a, v);
      if (!v[3]) begin ok = 1; break; end
    end
    check(ok, req, int'(ok), 1);
  endtask

  task automatic manualFrame(input bit [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); manClk = 0; manData = b[i];
      repeat (4) @(negedge clk);
      manClk = 1;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    bit [7:0] v;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    rd(3'd0, v); check(v == 8'h00, "R1 tx control", v, 0);
    rd(3'd1, v); check(v == 8'h00, "R1 tx buffer", v, 0);
    rd(3'd2, v); check(v == 8'h00, "R1 baud", v, 0);
    rd(3'd4, v); check(v == 8'h00, "R1 rx control", v, 0);
    rd(3'd5, v); check(v == 8'h00, "R1 rx buffer", v, 0);
    check(txClk && txData, "R1 pins high", int'({txClk, txData}), 3);
    check(!txIrq && !rxIrq, "R1 irqs low", int'({txIrq, rxIrq}), 0);

    // R12: map and read-only receive buffer
    wr(3'd2, 8'hAB); rd(3'd2, v); check(v == 8'hAB, "R12 baud readback", v, 8'hAB);
    wr(3'd5, 8'hFF); rd(3'd5, v); check(v == 8'h00, "R12 rx buffer read-only", v, 0);
    wr(3'd4, 8'hA0); rd(3'd4, v); check(v == 8'h00, "R12 rx bits 7 and 5 read 0", v, 0);

    // Loopback, 8 bits MSB first, half period 2
    wr(3'd2, 8'hFE);
    wr(3'd4, 8'h0C);
    wr(3'd1, 8'hA5);
    wr(3'd0, 8'h8D);
    waitIdle(3'd0, "R2 tx completes");
    waitIdle(3'd4, "R7 rx completes");
    rd(3'd0, v); check(v == 8'h87, "R2 tx done flag", v, 8'h87);
    rd(3'd5, v); check(v == 8'hA5, "R7 R5 msb-first byte", v, 8'hA5);
    rd(3'd4, v); check(v == 8'h06, "R7 rx done flag", v, 8'h06);
    check(txIrq && !rxIrq, "R11 irq pair", int'({txIrq, rxIrq}), 2);

    // 7 bits LSB first, gated ticks, half period 3
    gateTicks = 1;
    wr(3'd2, 8'hFD);
    wr(3'd4, 8'h18);
    wr(3'd1, 8'hC3);
    wr(3'd0, 8'h98);
    waitIdle(3'd0, "R3 gated tx completes");
    waitIdle(3'd4, "R4 rx 7-bit completes");
    rd(3'd5, v); check(v == 8'h43, "R4 R5 lsb-first 7-bit byte", v, 8'h43);

    // R8: overrun on receive
    wr(3'd4, 8'h1A);
    wr(3'd1, 8'h11);
    wr(3'd0, 8'h98);
    waitIdle(3'd0, "R8 tx completes");
    waitIdle(3'd4, "R8 rx completes");
    gateTicks = 0;
    rd(3'd4, v); check(v == 8'h52, "R8 overrun flag", v, 8'h52);
    rd(3'd5, v); check(v == 8'h43, "R8 buffer kept", v, 8'h43);

    // R10: write-0-to-clear
    wr(3'd4, 8'h42); rd(3'd4, v); check(v == 8'h42, "R10 write 1 keeps flags", v, 8'h42);
    wr(3'd4, 8'h00); rd(3'd4, v); check(v == 8'h00, "R10 write 0 clears flags", v, 0);

    // R9/R10: tx overrun, no abort; R7: unarmed receiver ignores edges
    wr(3'd2, 8'hF0);
    wr(3'd1, 8'h3C);
    wr(3'd0, 8'h8C);
    wr(3'd1, 8'h99);
    rd(3'd1, v); check(v == 8'h3C, "R9 buffer write dropped", v, 8'h3C);
    rd(3'd0, v); check(v == 8'hCC, "R9 tx overrun flag", v, 8'hCC);
    wr(3'd0, 8'h80);
    rd(3'd0, v); check(v == 8'h88, "R10 frame not aborted", v, 8'h88);
    waitIdle(3'd0, "R10 tx completes");
    rd(3'd5, v); check(v == 8'h43, "R7 unarmed buffer unchanged", v, 8'h43);
    rd(3'd4, v); check(v == 8'h00, "R7 unarmed control unchanged", v, 0);

    // R6: clock pin gated off, receiver armed sees no edges
    wr(3'd2, 8'hFE);
    wr(3'd4, 8'h0D);
    wr(3'd1, 8'h55);
    lowSeen = 0; monLow = 1;
    wr(3'd0, 8'h08);
    waitIdle(3'd0, "R6 tx completes");
    monLow = 0;
    check(lowSeen == 0, "R6 txClk held high", lowSeen, 0);
    repeat (6) @(negedge clk);
    rd(3'd4, v); check(v == 8'h0D, "R6 rx still armed", v, 8'h0D);
    rd(3'd5, v); check(v == 8'h43, "R6 rx buffer unchanged", v, 8'h43);

    // R7/R11: external clock drives the armed receiver
    loopSel = 0;
    manualFrame(8'h6E);
    repeat (6) @(negedge clk);
    rd(3'd4, v); check(v == 8'h07, "R7 external frame done", v, 8'h07);
    rd(3'd5, v); check(v == 8'h6E, "R7 external byte", v, 8'h6E);
    check(rxIrq == 1'b1, "R11 rx irq", int'(rxIrq), 1);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule